// File: doc/BRIEF.md
# Stop Mode Entry and Recovery Controller

This controller sits between a processor core and the oscillator that clocks it, and it decides when the core's clock may run. It receives a decoded stop-instruction strobe from the core. When stopping is permitted, it gates the core clock off and flags that the part is stopped. When stopping is forbidden, it reports an illegal-opcode event and the core keeps running. When a wake-up interrupt or a reset arrives, it counts oscillator cycles before it enables the core clock again. The same delay also covers power-on.

The delay depends on what ended the stop. An interrupt wake-up follows the short-recovery option, which gives 32 or 4096 cycles. Power-on and any reset always take the 4096-cycle path. A three-bit option word is captured when reset is released and stays fixed until the next reset. It holds a stop-permit bit, a short-recovery bit and a watchdog-off bit.

The state machine has four states. HOLD is entered on power-on or while the reset input is low. RECOVER counts the oscillator cycles. RUN is the state in which the core clock is enabled. STOP is the state in which the clock is gated. The transitions are:
- HOLD to RECOVER when reset is released. This loads the long count and captures the options.
- RECOVER to RUN at the terminal count.
- RUN to STOP on a permitted stop strobe.
- STOP to RECOVER on a wake interrupt.
- Any state to HOLD while the reset input is low.

Top module: `stop_recovery_ctrl`

## Requirements
- R1: With short recovery selected, an interrupt wake-up from STOP makes `cpu_ready` high for exactly one cycle, in the 32nd cycle after the edge that took the wake request. `cpu_clk_en` rises in the cycle after that.
- R2: With short recovery not selected, an interrupt wake-up gives the same sequence, but with 4096 counted cycles.
- R3: A stop exit caused by the reset input always takes 4096 cycles, even when short recovery is selected. `cpu_ready` occurs in the 4096th cycle after the edge that sees the reset input high again.
- R4: After `por_n` is released, the core clock stays off for 4096 counted cycles, followed by one `cpu_ready` pulse.
- R5: In RUN with the stop-permit bit 0, `stop_cmd` drives `illegal_op` high in that same cycle. No stop follows: `cpu_clk_en` stays 1 and `stop_active` stays 0.
- R6: In RUN with the stop-permit bit 1, `stop_cmd` makes the next cycle show `stop_active` = 1 and `cpu_clk_en` = 0. The stopped state persists until a wake-up or a reset.
- R7: `wdog_en` equals the inverse of the captured watchdog-off bit.
- R8: `cpu_ready` is never high for two cycles in a row. `cpu_clk_en` stays 0 throughout every recovery.
- R9: A wake request that arrives during a recovery does not restart the count. `wake_pend` is high in the cycle of the `cpu_ready` pulse after an interrupt wake-up.
- R10: When the reset input goes low during a short recovery, that recovery is abandoned, and a full 4096-cycle count follows the reset release.
- R11: The option inputs are captured only at reset release. Changing them in RUN has no effect on stop permission, recovery length or `wdog_en` until the next reset.
- R12: While `por_n` or `rst_n` is low, `cpu_clk_en`, `cpu_ready` and `stop_active` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Free-running oscillator clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| rst_n | input | 1 | System reset, sampled on osc_clk, active low |
| stop_cmd | input | 1 | Decoded stop-instruction strobe, valid in RUN |
| wake_irq | input | 1 | Wake-up interrupt request |
| opt_stop_en | input | 1 | Option: stop instruction permitted |
| opt_short_rec | input | 1 | Option: short recovery for interrupt wake-up |
| opt_wdog_off | input | 1 | Option: watchdog held off |
| cpu_clk_en | output | 1 | Enable for the core clock gate (RUN) |
| stop_active | output | 1 | Part is in stop mode |
| cpu_ready | output | 1 | One-cycle pulse on the final recovery cycle |
| illegal_op | output | 1 | Stop strobe rejected as an illegal opcode |
| wake_pend | output | 1 | Wake interrupt latched for the core |
| wdog_en | output | 1 | Watchdog enable |

## Verification
Some properties are checked on every cycle. `cpu_ready` is a single-cycle pulse, and the clock comes on right after it. The clock is off while stopped and while reset is low. A permitted stop strobe is always followed by STOP, and a rejected one leaves the core clock running. A latched wake stays latched until release. `wdog_en` stays constant in RUN. Finally, a cycle counter bounds the length of any clock-off stretch outside STOP. The exact recovery lengths must be shown by the bench scenarios, counted from a known edge: 32 versus 4096 cycles, and the choice made by the exit cause. The same applies to a reset that cuts a short count, a second wake in mid-count, and option changes in RUN that have no effect.

// File: rtl/stop_ctrl_pkg.sv
package stop_ctrl_pkg;

    typedef enum logic [1:0] {
        ST_HOLD    = 2'd0,
        ST_RECOVER = 2'd1,
        ST_RUN     = 2'd2,
        ST_STOP    = 2'd3
    } stop_state_t;

    typedef struct packed {
        logic stop_en;
        logic short_rec;
        logic wdog_off;
    } stop_opt_t;

    localparam stop_opt_t OPT_RESET = '{stop_en: 1'b0, short_rec: 1'b0, wdog_off: 1'b0};

endpackage

// File: rtl/stop_opt_latch.sv
module stop_opt_latch
    import stop_ctrl_pkg::*;
(
    input  logic      clk,
    input  logic      por_n,
    input  logic      capture,
    input  stop_opt_t opt_in,
    output stop_opt_t opt_q
);

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            opt_q <= OPT_RESET;
        end else if (capture) begin
            opt_q <= opt_in;
        end
    end

endmodule

// File: rtl/stop_rec_counter.sv
module stop_rec_counter #(
    parameter int LONG_CYC  = 4096,
    parameter int SHORT_CYC = 32
) (
    input  logic clk,
    input  logic por_n,
    input  logic load,
    input  logic long_sel,
    output logic done
);

    localparam int CNT_W = $clog2(LONG_CYC);
    localparam logic [CNT_W-1:0] LONG_LD  = CNT_W'(LONG_CYC - 1);
    localparam logic [CNT_W-1:0] SHORT_LD = CNT_W'(SHORT_CYC - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= long_sel ? LONG_LD : SHORT_LD;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);

endmodule

// File: rtl/stop_fsm.sv
module stop_fsm
    import stop_ctrl_pkg::*;
(
    input  logic        clk,
    input  logic        por_n,
    input  logic        rst_n,
    input  logic        stop_cmd,
    input  logic        wake_irq,
    input  logic        stop_en,
    input  logic        short_rec,
    input  logic        rec_done,
    output logic        cnt_load,
    output logic        cnt_long,
    output logic        opt_capture,
    output logic        cpu_clk_en,
    output logic        stop_active,
    output logic        cpu_ready,
    output logic        illegal_op,
    output logic        wake_pend
);

    stop_state_t state_q, state_nx;
    logic        pend_q;

    // State register
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            state_q <= ST_HOLD;
        end else begin
            state_q <= state_nx;
        end
    end

    // Next state
    always_comb begin
        state_nx = state_q;
        if (!rst_n) begin
            state_nx = ST_HOLD;
        end else begin
            unique case (state_q)
                ST_HOLD:    state_nx = ST_RECOVER;
                ST_RECOVER: if (rec_done) state_nx = ST_RUN;
                ST_RUN:     if (stop_cmd && stop_en) state_nx = ST_STOP;
                ST_STOP:    if (wake_irq) state_nx = ST_RECOVER;
                default:    state_nx = ST_HOLD;
            endcase
        end
    end

    // Latched wake request, held until the core is released
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            pend_q <= 1'b0;
        end else if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (state_q == ST_RECOVER && rec_done) begin
            pend_q <= 1'b0;
        end else if ((state_q == ST_STOP || state_q == ST_RECOVER) && wake_irq) begin
            pend_q <= 1'b1;
        end
    end

    // Outputs
    always_comb begin
        cpu_clk_en  = 1'b0;
        stop_active = 1'b0;
        cpu_ready   = 1'b0;
        illegal_op  = 1'b0;
        opt_capture = 1'b0;
        unique case (state_q)
            ST_HOLD: begin
                opt_capture = rst_n;
            end
            ST_RECOVER: begin
                cpu_ready = rec_done;
            end
            ST_RUN: begin
                cpu_clk_en = 1'b1;
                illegal_op = stop_cmd && !stop_en;
            end
            ST_STOP: begin
                stop_active = 1'b1;
            end
            default: begin
                cpu_clk_en = 1'b0;
            end
        endcase
        cnt_load  = (state_q != ST_RECOVER) && (state_nx == ST_RECOVER);
        cnt_long  = (state_q == ST_HOLD) || !short_rec;
        wake_pend = pend_q;
    end

endmodule

// File: rtl/stop_recovery_ctrl.sv
module stop_recovery_ctrl
    import stop_ctrl_pkg::*;
#(
    parameter int LONG_CYC  = 4096,
    parameter int SHORT_CYC = 32
) (
    input  logic osc_clk,
    input  logic por_n,
    input  logic rst_n,
    input  logic stop_cmd,
    input  logic wake_irq,
    input  logic opt_stop_en,
    input  logic opt_short_rec,
    input  logic opt_wdog_off,
    output logic cpu_clk_en,
    output logic stop_active,
    output logic cpu_ready,
    output logic illegal_op,
    output logic wake_pend,
    output logic wdog_en
);

    stop_opt_t opt_in, opt_q;
    logic      capture, cnt_load, cnt_long, rec_done;

    assign opt_in = '{stop_en: opt_stop_en, short_rec: opt_short_rec, wdog_off: opt_wdog_off};

    stop_opt_latch u_opt (
        .clk     (osc_clk),
        .por_n   (por_n),
        .capture (capture),
        .opt_in  (opt_in),
        .opt_q   (opt_q)
    );

    stop_rec_counter #(
        .LONG_CYC  (LONG_CYC),
        .SHORT_CYC (SHORT_CYC)
    ) u_cnt (
        .clk      (osc_clk),
        .por_n    (por_n),
        .load     (cnt_load),
        .long_sel (cnt_long),
        .done     (rec_done)
    );

    stop_fsm u_fsm (
        .clk         (osc_clk),
        .por_n       (por_n),
        .rst_n       (rst_n),
        .stop_cmd    (stop_cmd),
        .wake_irq    (wake_irq),
        .stop_en     (opt_q.stop_en),
        .short_rec   (opt_q.short_rec),
        .rec_done    (rec_done),
        .cnt_load    (cnt_load),
        .cnt_long    (cnt_long),
        .opt_capture (capture),
        .cpu_clk_en  (cpu_clk_en),
        .stop_active (stop_active),
        .cpu_ready   (cpu_ready),
        .illegal_op  (illegal_op),
        .wake_pend   (wake_pend)
    );

    assign wdog_en = !opt_q.wdog_off;

endmodule

// File: rtl/stop_ctrl_checker.sv
module stop_ctrl_checker #(
    parameter int LONG_CYC = 4096
) (
    input logic osc_clk,
    input logic por_n,
    input logic rst_n,
    input logic stop_cmd,
    input logic cpu_clk_en,
    input logic stop_active,
    input logic cpu_ready,
    input logic illegal_op,
    input logic wake_pend,
    input logic wdog_en
);

    localparam int LEN_W = $clog2(LONG_CYC) + 2;

    logic [LEN_W-1:0] off_len;

    always_ff @(posedge osc_clk or negedge por_n) begin
        if (!por_n) begin
            off_len <= '0;
        end else if (!rst_n || cpu_clk_en || stop_active) begin
            off_len <= '0;
        end else if (off_len != {LEN_W{1'b1}}) begin
            off_len <= off_len + 1'b1;
        end
    end

    AST_READY_ONE_CYCLE: assert property (@(posedge osc_clk) disable iff (!por_n)
        cpu_ready |=> !cpu_ready); // R8

    AST_READY_RELEASES: assert property (@(posedge osc_clk) disable iff (!por_n)
        (cpu_ready && rst_n) |=> cpu_clk_en); // R8

    AST_STOP_GATES_CLOCK: assert property (@(posedge osc_clk) disable iff (!por_n)
        stop_active |-> !cpu_clk_en); // R6

    AST_STOP_ENTRY: assert property (@(posedge osc_clk) disable iff (!por_n)
        (cpu_clk_en && stop_cmd && !illegal_op && rst_n) |=> stop_active); // R6

    AST_ILLEGAL_KEEPS_RUN: assert property (@(posedge osc_clk) disable iff (!por_n)
        (illegal_op && rst_n) |=> (cpu_clk_en && !stop_active)); // R5

    AST_RESET_HOLDS_OFF: assert property (@(posedge osc_clk) disable iff (!por_n)
        !rst_n |=> (!cpu_clk_en && !cpu_ready && !stop_active)); // R12

    AST_WDOG_FIXED_IN_RUN: assert property (@(posedge osc_clk) disable iff (!por_n)
        (cpu_clk_en && rst_n) |=> $stable(wdog_en)); // R11

    AST_PEND_HELD: assert property (@(posedge osc_clk) disable iff (!por_n)
        (wake_pend && !cpu_ready && rst_n) |=> wake_pend); // R9

    AST_RECOVERY_BOUND: assert property (@(posedge osc_clk) disable iff (!por_n)
        off_len <= LEN_W'(LONG_CYC + 1)); // R2

endmodule

bind stop_recovery_ctrl stop_ctrl_checker #(.LONG_CYC(LONG_CYC)) u_chk (
    .osc_clk     (osc_clk),
    .por_n       (por_n),
    .rst_n       (rst_n),
    .stop_cmd    (stop_cmd),
    .cpu_clk_en  (cpu_clk_en),
    .stop_active (stop_active),
    .cpu_ready   (cpu_ready),
    .illegal_op  (illegal_op),
    .wake_pend   (wake_pend),
    .wdog_en     (wdog_en)
);

// File: tb/test_stop_recovery_ctrl.sv
module test_stop_recovery_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int LONG_N     = 4096;
    localparam int SHORT_N    = 32;

    logic osc_clk = 1'b0;
    logic por_n = 1'b0, rst_n = 1'b1, stop_cmd = 1'b0, wake_irq = 1'b0;
    logic opt_stop_en = 1'b1, opt_short_rec = 1'b1, opt_wdog_off = 1'b0;
    logic cpu_clk_en, stop_active, cpu_ready, illegal_op, wake_pend, wdog_en;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) osc_clk = ~osc_clk;

    stop_recovery_ctrl i_stop_recovery_ctrl (
        .osc_clk       (osc_clk),
        .por_n         (por_n),
        .rst_n         (rst_n),
        .stop_cmd      (stop_cmd),
        .wake_irq      (wake_irq),
        .opt_stop_en   (opt_stop_en),
        .opt_short_rec (opt_short_rec),
        .opt_wdog_off  (opt_wdog_off),
        .cpu_clk_en    (cpu_clk_en),
        .stop_active   (stop_active),
        .cpu_ready     (cpu_ready),
        .illegal_op    (illegal_op),
        .wake_pend     (wake_pend),
        .wdog_en       (wdog_en)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Counts negedges from the current one until cpu_clk_en is seen.
    // wake_irq is driven high again at count extra_at (0 = never).
    task automatic wait_release(input int n, input string req, input int extra_at,
                                input bit want_pend);
        int k = 0, ready_at = -1, readys = 0, pend_at_ready = 0, clk_on_early = 0;
        while (k < n + 20) begin
            @(negedge osc_clk);
            k++;
            wake_irq = (k == extra_at);
            if (cpu_ready) begin
                readys++;
                ready_at = k;
                pend_at_ready = int'(wake_pend);
            end
            if (cpu_clk_en) break;
            if (cpu_clk_en && k <= n) clk_on_early++;
        end
        wake_irq = 1'b0;
        check(k == n + 1, req, "cycles until cpu_clk_en", k, n + 1);
        check(ready_at == n, req, "cpu_ready cycle", ready_at, n);
        check(readys == 1, "R8", "cpu_ready pulse count", readys, 1);
        if (want_pend) check(pend_at_ready == 1, "R9", "wake_pend at cpu_ready", pend_at_ready, 1);
    endtask

    task automatic enter_stop();
        @(negedge osc_clk);
        stop_cmd = 1'b1;
        @(negedge osc_clk);
        stop_cmd = 1'b0;
        check(stop_active == 1'b1, "R6", "stop_active after stop_cmd", int'(stop_active), 1);
        check(cpu_clk_en == 1'b0, "R6", "cpu_clk_en in stop", int'(cpu_clk_en), 0);
    endtask

    task automatic reset_pulse(input string req);
        @(negedge osc_clk);
        rst_n = 1'b0;
        @(negedge osc_clk);
        check(!cpu_clk_en && !cpu_ready && !stop_active, "R12", "outputs in reset",
              int'({cpu_clk_en, cpu_ready, stop_active}), 0);
        @(negedge osc_clk);
        rst_n = 1'b1;
        wait_release(LONG_N, req, 0, 1'b0);
    endtask

    task automatic t_power_on();
        repeat (3) @(negedge osc_clk);
        check(!cpu_clk_en && !cpu_ready && !stop_active, "R12", "outputs in power-on",
              int'({cpu_clk_en, cpu_ready, stop_active}), 0);
        por_n = 1'b1;
        wait_release(LONG_N, "R4", 0, 1'b0);
        check(wdog_en == 1'b1, "R7", "wdog_en with watchdog-off 0", int'(wdog_en), 1);
    endtask

    task automatic t_short_wake();
        enter_stop();
        repeat (5) @(negedge osc_clk);
        check(stop_active == 1'b1, "R6", "stop persists", int'(stop_active), 1);
        wake_irq = 1'b1;
        wait_release(SHORT_N, "R1", 0, 1'b1);
    endtask

    task automatic t_wake_during_recovery();
        enter_stop();
        wake_irq = 1'b1;
        wait_release(SHORT_N, "R9", 10, 1'b1);
    endtask

    task automatic t_reset_from_stop();
        enter_stop();
        reset_pulse("R3");
    endtask

    task automatic t_reset_aborts_short();
        enter_stop();
        @(negedge osc_clk);
        wake_irq = 1'b1;
        @(negedge osc_clk);
        wake_irq = 1'b0;
        repeat (9) @(negedge osc_clk);
        check(cpu_clk_en == 1'b0, "R10", "still recovering before reset", int'(cpu_clk_en), 0);
        reset_pulse("R10");
    endtask

    task automatic t_illegal_and_options();
        opt_stop_en = 1'b0; opt_short_rec = 1'b0; opt_wdog_off = 1'b1;
        reset_pulse("R3");
        check(wdog_en == 1'b0, "R7", "wdog_en with watchdog-off 1", int'(wdog_en), 0);
        @(negedge osc_clk);
        stop_cmd = 1'b1;
        #1;
        check(illegal_op == 1'b1, "R5", "illegal_op on forbidden stop", int'(illegal_op), 1);
        @(negedge osc_clk);
        stop_cmd = 1'b0;
        check(cpu_clk_en && !stop_active, "R5", "run kept after illegal stop",
              int'({cpu_clk_en, stop_active}), 2);
        // options changed in RUN are not taken
        opt_stop_en = 1'b1; opt_wdog_off = 1'b0;
        @(negedge osc_clk);
        check(wdog_en == 1'b0, "R11", "wdog_en after option change in run", int'(wdog_en), 0);
        stop_cmd = 1'b1;
        #1;
        check(illegal_op == 1'b1, "R11", "stop still forbidden", int'(illegal_op), 1);
        @(negedge osc_clk);
        stop_cmd = 1'b0;
        check(stop_active == 1'b0, "R11", "no stop entered", int'(stop_active), 0);
    endtask

    task automatic t_long_wake();
        reset_pulse("R4");
        check(wdog_en == 1'b1, "R7", "wdog_en recaptured", int'(wdog_en), 1);
        opt_short_rec = 1'b1;
        enter_stop();
        @(negedge osc_clk);
        stop_cmd = 1'b1;
        @(negedge osc_clk);
        stop_cmd = 1'b0;
        check(stop_active == 1'b1, "R6", "stop_cmd ignored in stop", int'(stop_active), 1);
        wake_irq = 1'b1;
        wait_release(LONG_N, "R2", 0, 1'b1);
    endtask

    initial begin
        t_power_on();
        t_short_wake();
        t_wake_during_recovery();
        t_reset_from_stop();
        t_reset_aborts_short();
        t_illegal_and_options();
        t_long_wake();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge osc_clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule